// File: doc/BRIEF.md
# Opcode-Decoded Accumulator ALU

This block is the arithmetic and logic stage of an 8-bit accumulator machine that runs the classic 8051 instruction encoding. It receives the raw opcode byte, the current accumulator, the contents of the register named by the opcode, an immediate byte and the carry flag. In the same cycle it returns the new accumulator value and the new carry. It decodes the opcode itself, including the eight-wide register-indexed opcode groups. It does not rely on a pre-encoded ALU operation field.

Fetching operands and reading the register file happen outside the block. To support this, the block exports the low three opcode bits as the register index, and the surrounding datapath uses that index to supply the register operand. The block is purely combinational. It also reports which instruction class it decoded, as a one-hot vector, and flags any opcode it does not implement. Such opcodes leave the accumulator and the carry untouched.

Top module: `acc_alu`

## Requirements
- R1: Opcodes 0x28 to 0x2F add the register operand to the accumulator: `acc_out` = (acc_in + reg_operand) mod 256, and `carry_out` is bit 8 of the 9-bit sum.
- R2: Opcode 0x94 subtracts with borrow: `acc_out` = (acc_in − imm_byte − carry_in) mod 256, and `carry_out` is 1 exactly when acc_in < imm_byte + carry_in.
- R3: Opcode 0x04 gives acc_in + 1 and opcode 0x14 gives acc_in − 1, both wrapping modulo 256, with `carry_out` equal to `carry_in`.
- R4: Opcode 0x54 gives acc_in AND imm_byte, and opcodes 0x58 to 0x5F give acc_in AND reg_operand. Carry passes through unchanged.
- R5: Opcodes 0x48 to 0x4F give acc_in OR reg_operand. Opcode 0x64 gives acc_in XOR imm_byte, and opcodes 0x68 to 0x6F give acc_in XOR reg_operand. Carry passes through unchanged.
- R6: Opcode 0xE4 gives 0x00 and opcode 0xF4 gives the bitwise inverse of acc_in. Carry passes through unchanged.
- R7: Opcode 0x03 rotates right, so bit 0 moves to bit 7. Opcode 0x23 rotates left, so bit 7 moves to bit 0. Neither rotate involves the carry, and `carry_out` equals `carry_in`.
- R8: `reg_idx` equals opcode bits [2:0] for every opcode byte.
- R9: Every other opcode gives `acc_out` = acc_in, `carry_out` = carry_in, `unsupported` = 1 and an all-zero `class_valid`. For supported opcodes, `unsupported` = 0.
- R10: For each supported opcode, `class_valid` has exactly one bit set. The bit positions are: 0 clear, 1 complement, 2 add, 3 subtract, 4 increment, 5 decrement, 6 AND, 7 OR, 8 XOR, 9 rotate right, 10 rotate left.
- R11: Register-indexed opcodes ignore `imm_byte`, and immediate opcodes ignore `reg_operand`. Only the operand named by the opcode affects `acc_out` and `carry_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 8 | Raw instruction opcode byte |
| acc_in | input | 8 | Current accumulator value |
| reg_operand | input | 8 | Contents of the register selected by `reg_idx` |
| imm_byte | input | 8 | Immediate operand byte |
| carry_in | input | 1 | Current carry flag |
| reg_idx | output | 3 | Register index taken from the opcode |
| acc_out | output | 8 | New accumulator value |
| carry_out | output | 1 | New carry flag |
| class_valid | output | 11 | One-hot decoded instruction class |
| unsupported | output | 1 | Opcode is not implemented |

## Verification
The assertions assume that every input is a known 0/1 value, and that the register operand already matches the index the block exports, because the checker never relates the two. The bench keeps within these assumptions. It drives every input from fully defined constants and treats `reg_operand` as a free value presented alongside the opcode. It sweeps all 256 opcode bytes against a set of accumulator values, operand values and both carry states. In every vector the register and immediate operands differ, so a wrong operand choice always shows up in the result.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DW     = 8;
    localparam int OPW    = 8;
    localparam int IDXW   = 3;
    localparam int NCLS   = 11;

    typedef enum logic [3:0] {
        OC_CLR  = 4'd0,
        OC_CPL  = 4'd1,
        OC_ADD  = 4'd2,
        OC_SUBB = 4'd3,
        OC_INC  = 4'd4,
        OC_DEC  = 4'd5,
        OC_AND  = 4'd6,
        OC_OR   = 4'd7,
        OC_XOR  = 4'd8,
        OC_RR   = 4'd9,
        OC_RL   = 4'd10,
        OC_NONE = 4'd15
    } op_cls_e;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic [OPW-1:0]  opcode,
    output op_cls_e         cls,
    output logic            use_reg,
    output logic [IDXW-1:0] idx,
    output logic [NCLS-1:0] onehot
);

    always_comb begin
        cls     = OC_NONE;
        use_reg = 1'b0;
        unique casez (opcode)
            8'h03:        cls = OC_RR;
            8'h04:        cls = OC_INC;
            8'h14:        cls = OC_DEC;
            8'h23:        cls = OC_RL;
            8'b0010_1???: begin cls = OC_ADD; use_reg = 1'b1; end
            8'b0100_1???: begin cls = OC_OR;  use_reg = 1'b1; end
            8'h54:        cls = OC_AND;
            8'b0101_1???: begin cls = OC_AND; use_reg = 1'b1; end
            8'h64:        cls = OC_XOR;
            8'b0110_1???: begin cls = OC_XOR; use_reg = 1'b1; end
            8'h94:        cls = OC_SUBB;
            8'hE4:        cls = OC_CLR;
            8'hF4:        cls = OC_CPL;
            default:      cls = OC_NONE;
        endcase
    end

    assign idx = opcode[IDXW-1:0];

    for (genvar i = 0; i < NCLS; i++) begin : g_onehot
        assign onehot[i] = (cls == op_cls_e'(i));
    end

endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
    import acc_alu_pkg::*;
(
    input  op_cls_e        cls,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic           cin,
    output logic [DW-1:0]  res,
    output logic           cout,
    output logic           cwr,
    output logic           hit
);

    localparam int XW = DW + 1;

    logic [XW-1:0] ext;

    always_comb begin
        ext = '0;
        cwr = 1'b0;
        hit = 1'b1;
        unique case (cls)
            OC_ADD: begin
                ext = {1'b0, a} + {1'b0, b};
                cwr = 1'b1;
            end
            OC_SUBB: begin
                ext = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
                cwr = 1'b1;
            end
            OC_INC:  ext = {1'b0, a} + {{DW{1'b0}}, 1'b1};
            OC_DEC:  ext = {1'b0, a} - {{DW{1'b0}}, 1'b1};
            default: hit = 1'b0;
        endcase
    end

    assign res  = ext[DW-1:0];
    assign cout = ext[DW];

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
(
    input  op_cls_e        cls,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    output logic [DW-1:0]  res,
    output logic           hit
);

    always_comb begin
        res = a;
        hit = 1'b1;
        unique case (cls)
            OC_CLR:  res = '0;
            OC_CPL:  res = ~a;
            OC_AND:  res = a & b;
            OC_OR:   res = a | b;
            OC_XOR:  res = a ^ b;
            OC_RR:   res = {a[0], a[DW-1:1]};
            OC_RL:   res = {a[DW-2:0], a[DW-1]};
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic [OPW-1:0]  opcode,
    input  logic [DW-1:0]   acc_in,
    input  logic [DW-1:0]   reg_operand,
    input  logic [DW-1:0]   imm_byte,
    input  logic            carry_in,
    output logic [IDXW-1:0] reg_idx,
    output logic [DW-1:0]   acc_out,
    output logic            carry_out,
    output logic [NCLS-1:0] class_valid,
    output logic            unsupported
);

    op_cls_e       cls;
    logic          use_reg;
    logic [DW-1:0] operand;
    logic [DW-1:0] ar_res;
    logic          ar_cout;
    logic          ar_cwr;
    logic          ar_hit;
    logic [DW-1:0] lg_res;
    logic          lg_hit;

    acc_alu_decode u_dec (
        .opcode  (opcode),
        .cls     (cls),
        .use_reg (use_reg),
        .idx     (reg_idx),
        .onehot  (class_valid)
    );

    assign operand = use_reg ? reg_operand : imm_byte;

    acc_alu_arith u_ar (
        .cls  (cls),
        .a    (acc_in),
        .b    (operand),
        .cin  (carry_in),
        .res  (ar_res),
        .cout (ar_cout),
        .cwr  (ar_cwr),
        .hit  (ar_hit)
    );

    acc_alu_logic u_lg (
        .cls (cls),
        .a   (acc_in),
        .b   (operand),
        .res (lg_res),
        .hit (lg_hit)
    );

    always_comb begin
        if (ar_hit) begin
            acc_out = ar_res;
        end else if (lg_hit) begin
            acc_out = lg_res;
        end else begin
            acc_out = acc_in;
        end
        carry_out   = ar_cwr ? ar_cout : carry_in;
        unsupported = ~(ar_hit | lg_hit);
    end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
(
    input logic [OPW-1:0]  opcode,
    input logic [DW-1:0]   acc_in,
    input logic [DW-1:0]   reg_operand,
    input logic [DW-1:0]   imm_byte,
    input logic            carry_in,
    input logic [DW-1:0]   acc_out,
    input logic            carry_out,
    input logic [NCLS-1:0] class_valid,
    input logic            unsupported
);

    always_comb begin
        // R9
        if (unsupported) begin
            unsup_hold_chk: assert (acc_out == acc_in && carry_out == carry_in && class_valid == '0);
        end
        // R10
        class_onehot_chk: assert ($onehot0(class_valid) && (unsupported == (class_valid == '0)));
        // R1
        if (opcode[7:3] == 5'b00101) begin
            add_sum_chk: assert ({carry_out, acc_out} == ({1'b0, acc_in} + {1'b0, reg_operand}));
        end
        // R3
        if (opcode == 8'h04 || opcode == 8'h14) begin
            incdec_carry_chk: assert (carry_out == carry_in);
        end
        // R6
        if (opcode == 8'hE4) begin
            clear_zero_chk: assert (acc_out == '0);
        end
        // R7
        if (opcode == 8'h03 || opcode == 8'h23) begin
            rotate_bits_chk: assert ($countones(acc_out) == $countones(acc_in) && carry_out == carry_in);
        end
        // R2
        if (opcode == 8'h94) begin
            subb_borrow_chk: assert (carry_out == ({1'b0, acc_in} < ({1'b0, imm_byte} + {8'd0, carry_in})));
        end
    end

endmodule

bind acc_alu acc_alu_chk u_chk (
    .opcode      (opcode),
    .acc_in      (acc_in),
    .reg_operand (reg_operand),
    .imm_byte    (imm_byte),
    .carry_in    (carry_in),
    .acc_out     (acc_out),
    .carry_out   (carry_out),
    .class_valid (class_valid),
    .unsupported (unsupported)
);

// File: tb/sim_acc_alu.sv
module sim_acc_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  acc_in = 8'h00;
    logic [7:0]  reg_operand = 8'h00;
    logic [7:0]  imm_byte = 8'h00;
    logic        carry_in = 1'b0;
    logic [2:0]  reg_idx;
    logic [7:0]  acc_out;
    logic        carry_out;
    logic [10:0] class_valid;
    logic        unsupported;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    acc_alu u0 (
        .opcode      (opcode),
        .acc_in      (acc_in),
        .reg_operand (reg_operand),
        .imm_byte    (imm_byte),
        .carry_in    (carry_in),
        .reg_idx     (reg_idx),
        .acc_out     (acc_out),
        .carry_out   (carry_out),
        .class_valid (class_valid),
        .unsupported (unsupported)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s op=%02h a=%02h r=%02h i=%02h c=%0d got=%0h exp=%0h",
                     tag, opcode, acc_in, reg_operand, imm_byte, carry_in, got, exp);
        end
    endtask

    // Expected behaviour computed from the requirements
    task automatic model(input logic [7:0] op, input logic [7:0] a, input logic [7:0] r,
                         input logic [7:0] im, input logic c,
                         output int ea, output int ec, output int ev, output int eu,
                         output string tag);
        int d;
        ea = a; ec = c; ev = 0; eu = 0; tag = "R9";
        if (op[7:3] == 5'b00101) begin
            d = a + r; ea = d % 256; ec = d / 256; ev = 1 << 2; tag = "R1";
        end else if (op == 8'h94) begin
            d = a - im - c; ea = (d + 512) % 256; ec = (d < 0) ? 1 : 0; ev = 1 << 3; tag = "R2";
        end else if (op == 8'h04) begin
            ea = (a + 1) % 256; ev = 1 << 4; tag = "R3";
        end else if (op == 8'h14) begin
            ea = (a + 255) % 256; ev = 1 << 5; tag = "R3";
        end else if (op == 8'h54) begin
            ea = a & im; ev = 1 << 6; tag = "R4";
        end else if (op[7:3] == 5'b01011) begin
            ea = a & r; ev = 1 << 6; tag = "R4";
        end else if (op[7:3] == 5'b01001) begin
            ea = a | r; ev = 1 << 7; tag = "R5";
        end else if (op == 8'h64) begin
            ea = a ^ im; ev = 1 << 8; tag = "R5";
        end else if (op[7:3] == 5'b01101) begin
            ea = a ^ r; ev = 1 << 8; tag = "R5";
        end else if (op == 8'hE4) begin
            ea = 0; ev = 1 << 0; tag = "R6";
        end else if (op == 8'hF4) begin
            ea = 255 - a; ev = 1 << 1; tag = "R6";
        end else if (op == 8'h03) begin
            ea = (a / 2) + ((a % 2) * 128); ev = 1 << 9; tag = "R7";
        end else if (op == 8'h23) begin
            ea = ((a * 2) % 256) + (a / 128); ev = 1 << 10; tag = "R7";
        end else begin
            eu = 1;
        end
    endtask

    task automatic apply(input logic [7:0] op, input logic [7:0] a, input logic [7:0] r,
                         input logic [7:0] im, input logic c);
        int ea, ec, ev, eu;
        string tag;
        @(negedge clk);
        opcode = op; acc_in = a; reg_operand = r; imm_byte = im; carry_in = c;
        #2;
        model(op, a, r, im, c, ea, ec, ev, eu, tag);
        chk(tag, acc_out, ea);
        chk(tag, carry_out, ec);
        chk("R9", unsupported, eu);
        chk("R10", class_valid, ev);
        chk("R8", reg_idx, op % 8);
    endtask

    initial begin
        logic [7:0] accs [8] = '{8'h00, 8'h01, 8'h0F, 8'h7F, 8'h80, 8'hFE, 8'hFF, 8'hA5};
        logic [7:0] regs [4] = '{8'h00, 8'h01, 8'hFF, 8'h3C};
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset-time state: opcode 0x00 is not implemented (R9)
        @(negedge clk);
        chk("R9", unsupported, 1);
        chk("R9", acc_out, 0);
        chk("R10", class_valid, 0);
        // full opcode sweep
        for (int op = 0; op < 256; op++) begin
            for (int ai = 0; ai < 8; ai++) begin
                for (int ri = 0; ri < 4; ri++) begin
                    for (int c = 0; c < 2; c++) begin
                        apply(8'(op), accs[ai], regs[ri], regs[ri] ^ 8'h96, 1'(c));
                    end
                end
            end
        end
        // R11: the unused operand has no effect on the result
        apply(8'h54, 8'hFF, 8'h00, 8'h0F, 1'b0);
        chk("R11", acc_out, 8'h0F);
        apply(8'h5B, 8'hFF, 8'hF0, 8'h0F, 1'b0);
        chk("R11", acc_out, 8'hF0);
        apply(8'h2A, 8'h10, 8'h05, 8'hFF, 1'b1);
        chk("R11", acc_out, 8'h15);
        apply(8'h94, 8'h10, 8'hFF, 8'h05, 1'b1);
        chk("R11", acc_out, 8'h0A);
        // R2 borrow boundary: equal values with carry set
        apply(8'h94, 8'h05, 8'h00, 8'h05, 1'b1);
        chk("R2", carry_out, 1);
        chk("R2", acc_out, 8'hFF);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule